// File: doc/BRIEF.md
# Timer Input Capture Unit

This block snapshots a free-running timer count when something happens on an external pin. It watches several capture pins. When a chosen transition occurs on a pin, the current counter value is copied into that pin's own capture register. Each channel can capture on a low-to-high transition, on a high-to-low transition, on both, or on neither. Each channel can also raise an interrupt request when its register is loaded.

Software uses a small word-addressed register port to reach the block:

| Address | Register | Access |
|---|---|---|
| 0 | Control word | Read/write |
| 1 | Interrupt flags | Read, write 1 to clear |
| 2 + k | Capture register of channel k | Read-only |

A separate input names the channel, if any, whose pin is being used as the counter's count source. That channel's control field is forced to all-zero while it is selected. The other channels keep working normally.

Pins are asynchronous to the clock. Each pin passes through a two-stage synchronizer. An edge detector then compares consecutive synchronized samples.

Top module: `tcap_unit`

## Requirements
- R1: After reset, the control word reads 0, the flag register reads 0, every capture register reads 0 and `irq_o` is low.
- R2: Control bits are laid out per channel. Bit 3k enables rising-edge capture for channel k. Bit 3k+1 enables falling-edge capture. Bit 3k+2 enables the interrupt. Bits at and above 3·NUM_CH ignore writes and read as 0.
- R3: With rising-edge enable set, a 0-to-1 change on pin k loads capture register k with `cnt_val_i` as sampled at the third rising clock edge after the change. With rising-edge enable clear, that change loads nothing.
- R4: With falling-edge enable set, a 1-to-0 change on pin k loads capture register k in the same way. With falling-edge enable clear, that change loads nothing.
- R5: With both edge enables set, every transition on pin k causes a load.
- R6: With both edge enables clear, pin k never changes its capture register.
- R7: Flag k (bit k of address 1) is set only by a load of channel k while its interrupt enable is set. Writing 1 to bit k clears flag k; writing 0 leaves it unchanged. `irq_o` is high exactly when any flag is set.
- R8: While `cnt_src_vld_i` is high and `cnt_src_sel_i` equals k, channel k neither loads nor flags. Other channels are unaffected, and the stored control word is unchanged.
- R9: Capture registers at addresses 2+k ignore writes.
- R10: One pin transition produces at most one load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val_i | input | CNT_W | Free-running timer count |
| cap_pin_i | input | NUM_CH | Asynchronous capture pins |
| cnt_src_vld_i | input | 1 | A channel is used as the count source |
| cnt_src_sel_i | input | CH_IDX_W | Index of that channel |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data (combinational from address) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is two channels capturing in the same cycle, each with a different edge polarity. Reaching it needs one pin pre-positioned high, with a capture disabled for that transition, before both pins toggle together. The stimulus sets that up: it raises channel 1, whose field is falling-only, then drops channel 1 and raises channel 2 on one clock. A scoreboard then checks both registers and both flags.

The count-source masking case is run the same way. Its selected channel toggles alongside an unmasked one, so the test shows that only the masked channel is silenced.

// File: rtl/tcap_pkg.sv
// Package: shared constants and types for the timer input capture unit.
// Assumes the control word packs one three-bit field per channel.
package tcap_pkg;

    localparam int FIELD_W    = 3;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_FLAG  = 1;
    localparam int ADDR_CAP0  = 2;

    // One channel's configuration, LSB first: rise enable, fall enable, irq enable.
    typedef struct packed {
        logic ien;
        logic fall_en;
        logic rise_en;
    } chan_cfg_t;

endpackage

// File: rtl/tcap_edge_det.sv
// Module: tcap_edge_det
// Synchronizes one asynchronous pin through SYNC_STAGES flops and flags
// single-cycle rising and falling events by comparing the last synchronized
// sample with the one before. Assumes SYNC_STAGES >= 2 and the pin idles low
// at reset.
module tcap_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the pin through the synchronizer and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Edge events from current versus previous synchronized sample.
    always_comb begin
        rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
        fall_o = ~sync_q[SYNC_STAGES-1] & prev_q;
    end

endmodule

// File: rtl/tcap_channel.sv
// Module: tcap_channel
// One capture channel. Loads the counter into its capture register on an
// enabled edge event and keeps a sticky interrupt flag. Assumes cfg_i has
// already been masked when the channel serves as count source. A set and a
// clear in the same cycle leave the flag set.
module tcap_channel #(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  tcap_pkg::chan_cfg_t cfg_i,
    input  logic                rise_i,
    input  logic                fall_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                flag_clr_i,
    output logic [CNT_W-1:0]    cap_o,
    output logic                flag_o,
    output logic                load_o
);

    // Decide whether this cycle's edge event is a capture.
    always_comb begin
        load_o = (cfg_i.rise_en & rise_i) | (cfg_i.fall_en & fall_i);
    end

    // Capture register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_o <= '0;
        end else if (load_o) begin
            cap_o <= cnt_i;
        end
    end

    // Sticky interrupt flag: set on flagged capture, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (load_o && cfg_i.ien) begin
            flag_o <= 1'b1;
        end else if (flag_clr_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/tcap_unit.sv
// Module: tcap_unit (top)
// Multi-channel input capture unit with a word-addressed register port.
// Address 0: control word, address 1: flags (W1C), address 2+k: capture k.
// Assumes CNT_W <= DATA_W and that all register addresses fit in ADDR_W.
module tcap_unit #(
    parameter int NUM_CH      = 4,
    parameter int CNT_W       = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CH_IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    cnt_val_i,
    input  logic [NUM_CH-1:0]   cap_pin_i,
    input  logic                cnt_src_vld_i,
    input  logic [CH_IDX_W-1:0] cnt_src_sel_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic                reg_wr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o
);

    import tcap_pkg::*;

    localparam int CTRL_W = NUM_CH * FIELD_W;

    logic [CTRL_W-1:0]       ctrl_q;
    logic [NUM_CH-1:0]       rise_vec;
    logic [NUM_CH-1:0]       fall_vec;
    logic [NUM_CH-1:0]       load_vec;
    logic [NUM_CH-1:0]       flag_vec;
    logic [NUM_CH-1:0]       flag_clr;
    logic [NUM_CH*CNT_W-1:0] cap_flat;
    logic                    wr_ctrl;
    logic                    wr_flag;

    // Decode write targets.
    always_comb begin
        wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CTRL));
        wr_flag = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_FLAG));
    end

    // Control word storage; only the channel fields are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= reg_wdata_i[CTRL_W-1:0];
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam logic [CH_IDX_W-1:0] KIDX = CH_IDX_W'(k);
        chan_cfg_t cfg_eff;

        // Force the field to zero while this pin is the count source.
        always_comb begin
            if (cnt_src_vld_i && (cnt_src_sel_i == KIDX)) begin
                cfg_eff = '0;
            end else begin
                cfg_eff = chan_cfg_t'(ctrl_q[k*FIELD_W +: FIELD_W]);
            end
        end

        // Write-one-to-clear request for this flag.
        always_comb begin
            flag_clr[k] = wr_flag && reg_wdata_i[k];
        end

        tcap_edge_det #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (cap_pin_i[k]),
            .rise_o (rise_vec[k]),
            .fall_o (fall_vec[k])
        );

        tcap_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_i      (cfg_eff),
            .rise_i     (rise_vec[k]),
            .fall_i     (fall_vec[k]),
            .cnt_i      (cnt_val_i),
            .flag_clr_i (flag_clr[k]),
            .cap_o      (cap_flat[k*CNT_W +: CNT_W]),
            .flag_o     (flag_vec[k]),
            .load_o     (load_vec[k])
        );
    end

    // Read multiplexer; unmapped addresses and reserved bits read zero.
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata_o = DATA_W'(ctrl_q);
        end else if (reg_addr_i == ADDR_W'(ADDR_FLAG)) begin
            reg_rdata_o = DATA_W'(flag_vec);
        end else begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (reg_addr_i == ADDR_W'(ADDR_CAP0 + k)) begin
                    reg_rdata_o = DATA_W'(cap_flat[k*CNT_W +: CNT_W]);
                end
            end
        end
    end

    // Interrupt request from any pending flag.
    always_comb begin
        irq_o = |flag_vec;
    end

endmodule

// File: rtl/tcap_unit_chk.sv
// Module: tcap_unit_chk
// Assertion checker bound to tcap_unit. Watches per-channel strobes, capture
// registers and flags. Assumes the same NUM_CH, CNT_W and CH_IDX_W as the top.
module tcap_unit_chk #(
    parameter int NUM_CH   = 4,
    parameter int CNT_W    = 32,
    parameter int CH_IDX_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CNT_W-1:0]        cnt_val_i,
    input logic                    cnt_src_vld_i,
    input logic [CH_IDX_W-1:0]     cnt_src_sel_i,
    input logic [NUM_CH-1:0]       rise_vec,
    input logic [NUM_CH-1:0]       load_vec,
    input logic [NUM_CH-1:0]       flag_vec,
    input logic [NUM_CH*CNT_W-1:0] cap_flat
);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        localparam logic [CH_IDX_W-1:0] KIDX = CH_IDX_W'(k);

        // R3: a load stores the counter value of the strobe cycle.
        p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
            load_vec[k] |=> cap_flat[k*CNT_W +: CNT_W] == $past(cnt_val_i));

        // R6: without a load the capture register holds.
        p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !load_vec[k] |=> $stable(cap_flat[k*CNT_W +: CNT_W]));

        // R7: a flag only rises after a load of its own channel.
        p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_vec[k]) |-> $past(load_vec[k]));

        // R8: the count-source channel never loads.
        p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_src_vld_i && cnt_src_sel_i == KIDX) |-> !load_vec[k]);

        // R10: a rising event lasts one cycle.
        p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
            rise_vec[k] |=> !rise_vec[k]);
    end

endmodule

bind tcap_unit tcap_unit_chk #(
    .NUM_CH   (NUM_CH),
    .CNT_W    (CNT_W),
    .CH_IDX_W (CH_IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_val_i     (cnt_val_i),
    .cnt_src_vld_i (cnt_src_vld_i),
    .cnt_src_sel_i (cnt_src_sel_i),
    .rise_vec      (rise_vec),
    .load_vec      (load_vec),
    .flag_vec      (flag_vec),
    .cap_flat      (cap_flat)
);

// File: tb/tcap_unit_tb.sv
// Scoreboard bench for tcap_unit: the driver toggles pins and pushes expected
// capture/flag snapshots; the monitor pops them and reads the register port.
module tcap_unit_tb;

    localparam int NUM_CH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cnt_val = '0;
    logic [3:0]  pins = '0;
    logic        src_vld = 1'b0;
    logic [1:0]  src_sel = '0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_busy = 1'b0;

    typedef struct {
        int          ch;
        logic [31:0] cap;
        logic [3:0]  flags;
        string       req;
    } item_t;

    item_t       q[$];
    logic [31:0] exp_cap [NUM_CH];
    logic [3:0]  exp_flags = '0;

    tcap_unit u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt_val_i     (cnt_val),
        .cap_pin_i     (pins),
        .cnt_src_vld_i (src_vld),
        .cnt_src_sel_i (src_sel),
        .reg_addr_i    (addr),
        .reg_wr_i      (wr),
        .reg_wdata_i   (wdata),
        .reg_rdata_o   (rdata),
        .irq_o         (irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // Change pins and counter together, then let the capture settle.
    task automatic drive(input logic [3:0] p, input logic [31:0] c);
        @(negedge clk);
        cnt_val = c;
        pins = p;
        repeat (4) @(negedge clk);
    endtask

    task automatic push(input int ch, input string req);
        item_t it;
        it.ch = ch; it.cap = exp_cap[ch]; it.flags = exp_flags; it.req = req;
        q.push_back(it);
    endtask

    task automatic wait_idle();
        wait (q.size() == 0 && !mon_busy);
    endtask

    // Monitor: pop expected snapshots and compare against the register port.
    initial begin
        item_t       it;
        logic [31:0] d;
        forever begin
            wait (q.size() != 0);
            mon_busy = 1'b1;
            it = q.pop_front();
            rd(4'(2 + it.ch), d);
            chk({it.req, " capture"}, d, it.cap);
            rd(4'd1, d);
            chk({it.req, " flags"}, d, {28'd0, it.flags});
            chk({it.req, " irq"}, {31'd0, irq}, {31'd0, |it.flags});
            mon_busy = 1'b0;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver.
    initial begin
        logic [31:0] d;
        for (int k = 0; k < NUM_CH; k++) exp_cap[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        rd(4'd0, d); chk("R1 ctrl", d, 32'h0);
        rd(4'd1, d); chk("R1 flags", d, 32'h0);
        for (int k = 0; k < NUM_CH; k++) begin
            rd(4'(2 + k), d); chk("R1 capture", d, 32'h0);
        end
        chk("R1 irq", {31'd0, irq}, 32'h0);

        // R2: reserved bits ignore writes; fields read back.
        wreg(4'd0, 32'hFFFF_F000);
        rd(4'd0, d); chk("R2 reserved", d, 32'h0);
        // ch0 rise only, ch1 fall+ien, ch2 both+ien, ch3 none.
        wreg(4'd0, 32'h0000_01F1);
        rd(4'd0, d); chk("R2 readback", d, 32'h1F1);

        // R3: rising capture on ch0, no flag (ien clear).
        drive(4'b0001, 32'h100); exp_cap[0] = 32'h100; push(0, "R3 rise ch0");
        wait_idle();
        drive(4'b0000, 32'h111); push(0, "R3 fall ignored ch0");
        wait_idle();

        // R4: ch1 ignores rise, captures on fall with flag.
        drive(4'b0010, 32'h200); push(1, "R4 rise ignored ch1");
        wait_idle();
        drive(4'b0000, 32'h222); exp_cap[1] = 32'h222; exp_flags[1] = 1'b1;
        push(1, "R4 fall ch1");
        wait_idle();

        // R7: write-one-to-clear; writing 1 to a clear flag does nothing.
        wreg(4'd1, 32'h1);
        rd(4'd1, d); chk("R7 w1c other bit", d, 32'h2);
        wreg(4'd1, 32'h2); exp_flags[1] = 1'b0;
        rd(4'd1, d); chk("R7 w1c clear", d, 32'h0);
        chk("R7 irq low", {31'd0, irq}, 32'h0);

        // R5: ch2 captures on both edges.
        drive(4'b0100, 32'h300); exp_cap[2] = 32'h300; exp_flags[2] = 1'b1;
        push(2, "R5 rise ch2");
        wait_idle();
        drive(4'b0000, 32'h333); exp_cap[2] = 32'h333; push(2, "R5 fall ch2");
        wait_idle();

        // R6: ch3 never captures.
        drive(4'b1000, 32'h400); push(3, "R6 rise ch3");
        wait_idle();
        drive(4'b0000, 32'h444); push(3, "R6 fall ch3");
        wait_idle();

        // R10/R4/R5: simultaneous ch1 fall and ch2 rise.
        drive(4'b0010, 32'h500); push(1, "R10 preset ch1");
        wait_idle();
        drive(4'b0100, 32'h555);
        exp_cap[1] = 32'h555; exp_cap[2] = 32'h555; exp_flags[1] = 1'b1;
        push(1, "R10 simultaneous ch1"); push(2, "R10 simultaneous ch2");
        wait_idle();

        // R8: ch2 is count source; ch0 still captures.
        @(negedge clk); src_vld = 1'b1; src_sel = 2'd2;
        drive(4'b0001, 32'h600); exp_cap[0] = 32'h600;
        push(2, "R8 masked ch2"); push(0, "R8 other ch0");
        wait_idle();
        rd(4'd0, d); chk("R8 ctrl kept", d, 32'h1F1);
        @(negedge clk); src_vld = 1'b0;

        // R9: capture registers ignore writes.
        wreg(4'd2, 32'hDEAD_BEEF);
        push(0, "R9 read-only ch0");
        wait_idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule